// File: doc/BRIEF.md
# Add-On FIFO Register Port

This block puts a 32-bit FIFO behind a single word of an add-on register space. The local side reaches it with a word address, active-low byte-lane enables, an active-low chip select, and active-low read and write strobes. The FIFO is decoded at byte offset 20h, which is word address 8 on the five-bit word address. A read drives the head word onto a data bus with a separate output-enable flag. A write pushes a word built from the enabled byte lanes. An empty flag reports the FIFO state.

Two access modes are chosen by a configuration input. In strobe-timed mode the strobes are asynchronous to the internal clock and pass through a two-flop synchronizer. A pop or push happens once per strobe, on its rising (releasing) edge. The data bus and the empty flag therefore keep their pre-access values for the whole access. In clocked mode the port pins are treated as synchronous to the internal clock. Every clock edge with a decoded read pops one word, and every clock edge with a decoded write pushes one word, which allows bursts.

Top module: `addon_fifo_port`

## Requirements
- R1: An access is decoded only while `sel_n` is 0, `word_addr` equals 8 (byte offset 20h), and at least one bit of `be_n` is 0. Writes that miss the decode leave the FIFO unchanged.
- R2: `dq_oe` is 1 exactly while a read is decoded and `rd_n` is 0. It then presents the head word on `dq_out`. While `dq_oe` is 0, `dq_out` is all zeros.
- R3: While a strobe-timed read access is held unchanged, `dq_out` holds the same head word.
- R4: In strobe-timed mode the read pointer advances once, a few clocks after the rising edge of `rd_n`, and never at its falling edge. If `sel_n` is released while `rd_n` is still low, the pointer does not advance.
- R5: `empty` keeps its pre-access value for the whole access. It changes only after the pointer moves, within 4 clocks of the strobe release.
- R6: A read of an empty FIFO returns all zeros on `dq_out` and does not move the pointer.
- R7: In strobe-timed mode a write pushes one word on the rising edge of `wr_n`. Byte i of the word (bits 8i+7 down to 8i) takes `dq_in` byte i when `be_n[i]` is 0, and is 0 otherwise.
- R8: A write while the FIFO holds DEPTH words is dropped.
- R9: With `sync_mode` at 1, each clock edge with a decoded read and a non-empty FIFO pops one word, and the next word appears after that edge. Each clock edge with a decoded write and a non-full FIFO pushes the lane-merged `dq_in`.
- R10: After reset the FIFO is empty, `empty` is 1, and `dq_oe` is 0.
- R11: Words leave the FIFO in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1 selects clocked burst mode, 0 selects strobe-timed mode |
| word_addr | input | 5 | Register word address (byte address bits 6 to 2) |
| be_n | input | 4 | Active-low byte-lane enables |
| sel_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data, zero when not driven |
| dq_oe | output | 1 | Read data bus output enable |
| empty | output | 1 | FIFO empty flag |

## Verification
The assertions assume `sync_mode` is static while the port is busy. In strobe-timed mode they also assume three things: strobes are held low and released high for at least three clocks, a read access and a write access never overlap, and a new read does not start before the previous release has been taken in. The stimulus drives every pin change at the falling clock edge. It spaces each strobe-timed access with several idle clocks after the release. It changes the mode only while the port is idle. It drives clocked-mode bursts as one held strobe across consecutive edges.

// File: rtl/afp_pkg.sv
package afp_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int ADDR_W  = 5;

  // Byte lane i is taken from the data when its active-low enable is 0.
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] d,
                                                   input logic [LANES-1:0]  en_n);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++)
      if (!en_n[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  // Port decode: select low, matching word, at least one lane enabled.
  function automatic logic port_hit(input logic              sel_n,
                                    input logic [ADDR_W-1:0] wa,
                                    input logic [ADDR_W-1:0] match,
                                    input logic [LANES-1:0]  en_n);
    return !sel_n && (wa == match) && (en_n != {LANES{1'b1}});
  endfunction
endpackage

// File: rtl/afp_strobe_sync.sv
module afp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  input  logic access,
  output logic acc_sync,
  output logic rel_pulse
);
  logic [STAGES-1:0] acc_ch;
  logic [STAGES-1:0] stb_ch;
  logic              acc_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_ch   <= '0;
      stb_ch   <= '1;
      acc_last <= 1'b0;
    end else begin
      acc_ch   <= {acc_ch[STAGES-2:0], access};
      stb_ch   <= {stb_ch[STAGES-2:0], strobe_n};
      acc_last <= acc_ch[STAGES-1];
    end
  end

  assign acc_sync  = acc_ch[STAGES-1];
  // Access ended and strobe is high: the strobe rose while the access was decoded.
  assign rel_pulse = acc_last && !acc_sync && stb_ch[STAGES-1];
endmodule

// File: rtl/afp_fifo_store.sv
module afp_fifo_store
  import afp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/addon_fifo_port.sv
module addon_fifo_port
  import afp_pkg::*;
#(
  parameter int              DEPTH     = 8,
  parameter int              SYNC_STG  = 2,
  parameter logic [ADDR_W-1:0] PORT_WORD = 5'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [LANES-1:0]  be_n,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              empty
);
  logic              hit;
  logic              rd_acc, wr_acc;
  logic              rd_acc_s, rd_rel;
  logic              wr_acc_s, wr_rel;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] push_data;
  logic [DATA_W-1:0] head;
  logic              full;
  logic              pop_evt, push_evt;

  assign hit    = port_hit(sel_n, word_addr, PORT_WORD, be_n);
  assign rd_acc = hit && !rd_n;
  assign wr_acc = hit && !wr_n;

  afp_strobe_sync #(.STAGES(SYNC_STG)) u_rsync (
    .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .access(rd_acc),
    .acc_sync(rd_acc_s), .rel_pulse(rd_rel)
  );

  afp_strobe_sync #(.STAGES(SYNC_STG)) u_wsync (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .access(wr_acc),
    .acc_sync(wr_acc_s), .rel_pulse(wr_rel)
  );

  // Write data is captured while the synchronized write access is seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_data <= '0;
    else if (wr_acc_s) cap_data <= lane_merge(dq_in, be_n);
  end

  assign pop_evt   = (sync_mode ? rd_acc : rd_rel) && !empty;
  assign push_evt  = (sync_mode ? wr_acc : wr_rel) && !full;
  assign push_data = sync_mode ? lane_merge(dq_in, be_n) : cap_data;

  afp_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .push_data(push_data),
    .pop(pop_evt), .head(head), .empty(empty), .full(full)
  );

  assign dq_oe  = rd_acc;
  assign dq_out = (rd_acc && !empty) ? head : '0;
endmodule

// File: rtl/afp_checks.sv
module afp_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        sync_mode,
  input logic        sel_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic [4:0]  word_addr,
  input logic        dq_oe,
  input logic [31:0] dq_out,
  input logic        empty,
  input logic        full,
  input logic        pop_evt,
  input logic        push_evt
);
  // R2: the bus is enabled only with select and read both low
  a_r2_oe_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!sel_n && !rd_n));

  // R2: a disabled bus carries zeros
  a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == 32'h0));

  // R6: no pop from an empty FIFO
  a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> !empty);

  // R8: no push into a full FIFO
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |-> !full);

  // R4: a strobe-timed pop happens only after the read strobe is high again
  a_r4_pop_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !sync_mode) |-> rd_n);

  // R7: a strobe-timed push happens only after the write strobe is high again
  a_r7_push_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && !sync_mode) |-> wr_n);

  // R3, R5: a held strobe-timed read keeps data and status
  a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && dq_oe && $past(dq_oe) && $stable(word_addr)) |->
      ($stable(empty) && $stable(dq_out)));

  // R5: empty only rises after a pop
  a_r5_empty_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> $past(pop_evt));
endmodule

bind addon_fifo_port afp_checks u_checks (
  .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .sel_n(sel_n),
  .rd_n(rd_n), .wr_n(wr_n), .word_addr(word_addr), .dq_oe(dq_oe),
  .dq_out(dq_out), .empty(empty), .full(full), .pop_evt(pop_evt),
  .push_evt(push_evt)
);

// File: tb/sim_addon_fifo_port.sv
module sim_addon_fifo_port;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        sync_mode = 0;
  logic [4:0]  word_addr = 0;
  logic [3:0]  be_n = 4'hF;
  logic        sel_n = 1, rd_n = 1, wr_n = 1;
  logic [31:0] dq_in = 0;
  logic [31:0] dq_out;
  logic        dq_oe, empty;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [31:0] exp_q [$];

  always #(CLK_P/2) clk = ~clk;

  addon_fifo_port #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .word_addr(word_addr),
    .be_n(be_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .empty(empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] d, input logic [3:0] en_n);
    logic [31:0] m = 0;
    for (int i = 0; i < 4; i++) m |= en_n[i] ? 32'h0 : (d & (32'hFF << (8*i)));
    return m;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: strobe-timed write; the expected word enters the scoreboard if it should land.
  task automatic awrite(input logic [4:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    word_addr = a; be_n = b; dq_in = d; sel_n = 0;
    @(negedge clk); wr_n = 0;
    idle(4);
    wr_n = 1;
    idle(1);
    sel_n = 1;
    idle(5);
    if (a == 5'h08 && b != 4'hF && exp_q.size() < DEPTH) exp_q.push_back(merge(d, b));
  endtask

  // Monitor: strobe-timed read compared with the scoreboard head.
  task automatic aread(input string req);
    logic [31:0] e;
    logic        emp;
    e   = (exp_q.size() > 0) ? exp_q[0] : 32'h0;
    emp = (exp_q.size() == 0);
    @(negedge clk);
    word_addr = 5'h08; be_n = 4'h0; sel_n = 0; rd_n = 0;
    #1;
    chk({req, " R2 oe on read"}, {31'h0, dq_oe}, 32'h1);
    chk({req, " R2 head word"}, dq_out, e);
    idle(3); #1;
    chk({req, " R3 data held"}, dq_out, e);
    chk({req, " R5 empty pre-read"}, {31'h0, empty}, {31'h0, emp});
    @(negedge clk); rd_n = 1; #1;
    chk({req, " R2 oe off"}, {31'h0, dq_oe}, 32'h0);
    chk({req, " R4 no advance yet"}, {31'h0, empty}, {31'h0, emp});
    @(negedge clk); sel_n = 1;
    idle(5);
    if (!emp) void'(exp_q.pop_front());
    chk({req, " R5 empty updated"}, {31'h0, empty}, {31'h0, exp_q.size() == 0});
  endtask

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_P*3 + 2);
    #1;
    chk("R10 empty in reset", {31'h0, empty}, 32'h1);
    chk("R10 oe in reset", {31'h0, dq_oe}, 32'h0);
    rst_n = 1;
    idle(3);

    // R6: read of empty gives zeros and keeps empty
    aread("R6 empty read");

    // R1: missed decodes do not push
    awrite(5'h09, 4'h0, 32'h1111_1111);
    awrite(5'h08, 4'hF, 32'h2222_2222);
    #1; chk("R1 wrong addr / no lanes ignored", {31'h0, empty}, 32'h1);

    // R7: lane merge, R11 order
    awrite(5'h08, 4'b0101, 32'hAABB_CCDD);
    awrite(5'h08, 4'b0000, 32'h1234_5678);
    awrite(5'h08, 4'b1110, 32'hFFFF_FF99);
    #1; chk("R7 push seen", {31'h0, empty}, 32'h0);
    aread("R7 R11 first");
    aread("R11 second");
    aread("R7 R11 third");

    // R4: select released before read strobe: no advance
    awrite(5'h08, 4'h0, 32'hCAFE_0001);
    @(negedge clk);
    word_addr = 5'h08; be_n = 4'h0; sel_n = 0; rd_n = 0;
    idle(3); sel_n = 1;
    idle(2); rd_n = 1;
    idle(6); #1;
    chk("R4 select-first release keeps word", {31'h0, empty}, 32'h0);
    aread("R4 word still at head");

    // R8: fill and overflow
    for (int k = 0; k < DEPTH; k++) awrite(5'h08, 4'h0, 32'h5000_0000 + k);
    awrite(5'h08, 4'h0, 32'hDEAD_BEEF);
    for (int k = 0; k < DEPTH; k++) aread("R8 R11 drain");
    #1; chk("R8 overflow dropped", {31'h0, empty}, 32'h1);

    // R9: clocked burst write then burst read
    sync_mode = 1;
    idle(2);
    word_addr = 5'h08; be_n = 4'h0; sel_n = 0;
    for (int k = 0; k < 4; k++) begin
      dq_in = 32'hA000_0000 + k; wr_n = 0;
      exp_q.push_back(32'hA000_0000 + k);
      @(negedge clk);
    end
    wr_n = 1; be_n = 4'b0011; dq_in = 32'h7788_9900; wr_n = 0;
    exp_q.push_back(32'h7788_0000);
    @(negedge clk); wr_n = 1; be_n = 4'h0;
    @(negedge clk); rd_n = 0;
    for (int k = 0; k < 5; k++) begin
      #1; chk("R9 burst word", dq_out, exp_q.pop_front());
      @(negedge clk);
    end
    #1;
    chk("R9 burst emptied", {31'h0, empty}, 32'h1);
    chk("R9 R6 empty burst read zero", dq_out, 32'h0);
    rd_n = 1; sel_n = 1;
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule